// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block is the digital sequencer that takes a multiphase core-voltage regulator from shutdown to regulation. It watches three qualified logic inputs: bias supply good, power-rail enable and termination-rail enable. Once all three are high, it waits through a fixed settling delay. It then ramps a digital reference code up to a boot level and holds it there while the load settles and a VID code becomes available. After that it samples the VID and ramps the reference to the requested level minus a programmed offset.

The block drives three outputs: the reference code for the external DAC, an output-enable for the PWM stage (low keeps the phase outputs high-impedance) and a ready flag. The ready flag follows the external regulation-window comparator once the final level is reached. A sampled VID equal to the OFF code parks the block in a locked shutdown. Only a drop of one of the three qualifying inputs releases it. The comparators, the DAC and the modulator are outside the block, and their results arrive as synchronous logic levels.

Top module: `vr_softstart_seq`

## Requirements
- R1: While any of `bias_por_ok`, `pwr_en_ok`, `vtt_en_ok` is low, and out of reset, `pwm_oe`, `ref_code` and `vr_ready` are all 0.
- R2: When all three qualifying inputs are first sampled high at a rising edge, `pwm_oe` rises exactly DELAY_CYC edges after that edge, with `ref_code` still 0.
- R3: In the first ramp, `ref_code` rises by one LSB every RAMP_DIV cycles, and the first step comes RAMP_DIV edges after `pwm_oe` rises. It stops exactly at BOOT_CODE.
- R4: `ref_code` stays at BOOT_CODE for HOLD_CYC cycles after the first ramp ends. The hold then lasts for as long as `vid_valid` is low, with `pwm_oe` kept high. With `vid_valid` already high, the code stays at BOOT_CODE for HOLD_CYC+RAMP_DIV+1 sampled cycles in total.
- R5: At the end of the hold, `vid` is sampled. The target is `vid - vid_offset`, clamped at 0. The second ramp moves one LSB every RAMP_DIV cycles, up or down, and stops exactly on the target.
- R6: A sampled `vid` equal to OFF_VID (all ones by default) clears `pwm_oe` and `ref_code` and keeps them cleared while the qualifying inputs stay high. After one of those inputs drops and returns, a full new start-up takes place.
- R7: `vr_ready` is 1 only at the final level, and only in a cycle after `in_window` was sampled high. It drops one edge after `in_window` is sampled low.
- R8: A drop of any qualifying input in any state clears `pwm_oe`, `ref_code` and `vr_ready` on the next rising edge.
- R9: Changes on `vid` and `vid_offset` after the sample do not move `ref_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bias_por_ok | input | 1 | Bias supply above its power-on threshold |
| pwr_en_ok | input | 1 | Power-rail enable comparator output |
| vtt_en_ok | input | 1 | Termination-rail enable comparator output |
| vid | input | CODE_W | Requested voltage code |
| vid_valid | input | 1 | VID lines are settled and may be sampled |
| vid_offset | input | CODE_W | Programmed offset subtracted from the VID |
| in_window | input | 1 | Output voltage is inside its regulation window |
| ref_code | output | CODE_W | Reference code for the DAC |
| pwm_oe | output | 1 | Enables the PWM outputs; 0 keeps them high-impedance |
| vr_ready | output | 1 | Regulator ready flag |

## Verification
A wrong sequencer state shows at the ports within one edge. If `pwm_oe` or `ref_code` stays nonzero after an enable drops, a clear was lost. A reference that moves by more than one LSB in a cycle, or passes the boot level in the first ramp, points to a broken ramp stepper. Timer or divider faults show up as delay, hold or step intervals that are off by whole cycles, so the bench counts these exactly from the edge that starts each phase. A lost OFF lock shows as `pwm_oe` coming back while the enables stay high.

// File: rtl/vrss_pkg.sv
package vrss_pkg;

  typedef enum logic [2:0] {
    ST_SHUT      = 3'd0,
    ST_DELAY     = 3'd1,
    ST_RAMP_BOOT = 3'd2,
    ST_HOLD      = 3'd3,
    ST_RAMP_TGT  = 3'd4,
    ST_RUN       = 3'd5,
    ST_OFF_LOCK  = 3'd6
  } vrss_state_e;

endpackage

// File: rtl/vrss_rst_sync.sv
module vrss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/vrss_timer.sv
module vrss_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] lim_m1,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == lim_m1);
  assign cnt_en = restart || !done;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/vrss_ramp.sv
module vrss_ramp #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RAMP_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              restart,
  input  logic              en,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] ref_o,
  output logic              at_tgt
);

  logic              div_tick;
  logic              step;
  logic [CODE_W-1:0] ref_q, ref_d;

  generate
    if (RAMP_DIV <= 1) begin : g_no_div
      assign div_tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DIV_W = $clog2(RAMP_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);
      logic [DIV_W-1:0] div_q, div_d;

      assign div_tick = (div_q == DIV_LAST);

      always_comb begin
        if (!en || restart || div_tick) div_d = '0;
        else                            div_d = div_q + DIV_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
    end
  endgenerate

  assign at_tgt = (ref_q == tgt);
  assign step   = en && !restart && div_tick && !at_tgt;

  always_comb begin
    if (zero)            ref_d = '0;
    else if (!step)      ref_d = ref_q;
    else if (ref_q < tgt) ref_d = ref_q + CODE_W'(1);
    else                 ref_d = ref_q - CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/vrss_fsm.sv
module vrss_fsm
  import vrss_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_all,
  input  logic        tmr_done,
  input  logic        at_tgt,
  input  logic        vid_valid,
  input  logic        vid_is_off,
  output vrss_state_e state_q,
  output vrss_state_e state_nxt,
  output logic        load_tgt
);

  always_comb begin
    state_nxt = state_q;
    load_tgt  = 1'b0;
    if (!en_all) begin
      state_nxt = ST_SHUT;
    end else begin
      case (state_q)
        ST_SHUT:      state_nxt = ST_DELAY;
        ST_DELAY:     if (tmr_done) state_nxt = ST_RAMP_BOOT;
        ST_RAMP_BOOT: if (at_tgt)   state_nxt = ST_HOLD;
        ST_HOLD: begin
          if (tmr_done && vid_valid) begin
            if (vid_is_off) begin
              state_nxt = ST_OFF_LOCK;
            end else begin
              state_nxt = ST_RAMP_TGT;
              load_tgt  = 1'b1;
            end
          end
        end
        ST_RAMP_TGT:  if (at_tgt) state_nxt = ST_RUN;
        ST_RUN:       state_nxt = ST_RUN;
        ST_OFF_LOCK:  state_nxt = ST_OFF_LOCK;
        default:      state_nxt = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SHUT;
    else        state_q <= state_nxt;
  end

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vrss_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned DELAY_CYC = 272000,
  parameter int unsigned HOLD_CYC  = 17000,
  parameter int unsigned RAMP_DIV  = 4,
  parameter logic [CODE_W-1:0] BOOT_CODE = 8'd110,
  parameter logic [CODE_W-1:0] OFF_VID   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_por_ok,
  input  logic              pwr_en_ok,
  input  logic              vtt_en_ok,
  input  logic [CODE_W-1:0] vid,
  input  logic              vid_valid,
  input  logic [CODE_W-1:0] vid_offset,
  input  logic              in_window,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_oe,
  output logic              vr_ready
);

  localparam int unsigned TMR_MAX = (DELAY_CYC > HOLD_CYC) ? DELAY_CYC : HOLD_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] DELAY_LIM = TMR_W'(DELAY_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LIM  = TMR_W'(HOLD_CYC - 1);

  logic              rst_int_n;
  logic              en_all;
  logic              tmr_done;
  logic              at_tgt;
  logic              load_tgt;
  logic              phase_chg;
  logic              ramp_en;
  logic              ramp_zero;
  logic              vid_is_off;
  logic [TMR_W-1:0]  tmr_lim;
  logic [CODE_W-1:0] ramp_tgt;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic              oe_q, oe_d;
  logic              rdy_q, rdy_d;
  vrss_state_e       state_q, state_nxt;

  vrss_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign en_all     = bias_por_ok && pwr_en_ok && vtt_en_ok;
  assign vid_is_off = (vid == OFF_VID);
  assign phase_chg  = (state_nxt != state_q);
  assign tmr_lim    = (state_q == ST_DELAY) ? DELAY_LIM : HOLD_LIM;
  assign ramp_en    = (state_q == ST_RAMP_BOOT) || (state_q == ST_RAMP_TGT);
  assign ramp_zero  = (state_nxt == ST_SHUT) || (state_nxt == ST_OFF_LOCK);
  assign ramp_tgt   = (state_q == ST_RAMP_BOOT) ? BOOT_CODE : tgt_q;

  vrss_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_all     (en_all),
    .tmr_done   (tmr_done),
    .at_tgt     (at_tgt),
    .vid_valid  (vid_valid),
    .vid_is_off (vid_is_off),
    .state_q    (state_q),
    .state_nxt  (state_nxt),
    .load_tgt   (load_tgt)
  );

  vrss_timer #(.CNT_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (phase_chg),
    .lim_m1  (tmr_lim),
    .done    (tmr_done)
  );

  vrss_ramp #(.CODE_W(CODE_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .zero    (ramp_zero),
    .restart (phase_chg),
    .en      (ramp_en),
    .tgt     (ramp_tgt),
    .ref_o   (ref_code),
    .at_tgt  (at_tgt)
  );

  // Target: requested code less offset, floored at zero
  always_comb begin
    if (vid > vid_offset) tgt_d = vid - vid_offset;
    else                  tgt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    tgt_q <= '0;
    else if (load_tgt) tgt_q <= tgt_d;
  end

  always_comb begin
    oe_d  = (state_nxt == ST_RAMP_BOOT) || (state_nxt == ST_HOLD) ||
            (state_nxt == ST_RAMP_TGT)  || (state_nxt == ST_RUN);
    rdy_d = (state_nxt == ST_RUN) && in_window;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      oe_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      rdy_q <= rdy_d;
    end
  end

  assign pwm_oe   = oe_q;
  assign vr_ready = rdy_q;

endmodule

// File: rtl/vrss_chk.sv
module vrss_chk
  import vrss_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] BOOT_CODE = 8'd110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bias_por_ok,
  input logic              pwr_en_ok,
  input logic              vtt_en_ok,
  input logic              in_window,
  input logic [CODE_W-1:0] ref_code,
  input logic              pwm_oe,
  input logic              vr_ready,
  input vrss_state_e       st
);

  logic all_on;
  assign all_on = bias_por_ok && pwr_en_ok && vtt_en_ok;

  // R8
  dropout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_on |=> (!pwm_oe && (ref_code == '0) && !vr_ready));

  // R1
  oe_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_oe) |-> $past(all_on));

  // R3
  boot_ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RAMP_BOOT) |-> (ref_code <= BOOT_CODE));

  // R5
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_oe |=> (!pwm_oe ||
                ({1'b0, ref_code} == {1'b0, $past(ref_code)}) ||
                ({1'b0, ref_code} == {1'b0, $past(ref_code)} + 1'b1) ||
                ({1'b0, ref_code} + 1'b1 == {1'b0, $past(ref_code)})));

  // R4
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (ref_code == BOOT_CODE && pwm_oe));

  // R7
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vr_ready |-> ($past(in_window) && st == ST_RUN));

  // R6
  off_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF_LOCK && all_on) |=> (st == ST_OFF_LOCK && !pwm_oe && ref_code == '0));

endmodule

bind vr_softstart_seq vrss_chk #(.CODE_W(CODE_W), .BOOT_CODE(BOOT_CODE)) u_vrss_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bias_por_ok (bias_por_ok),
  .pwr_en_ok   (pwr_en_ok),
  .vtt_en_ok   (vtt_en_ok),
  .in_window   (in_window),
  .ref_code    (ref_code),
  .pwm_oe      (pwm_oe),
  .vr_ready    (vr_ready),
  .st          (state_q)
);

// File: tb/test_vr_softstart_seq.sv
module test_vr_softstart_seq;

  localparam int unsigned CODE_W = 8;
  localparam int unsigned DLY    = 20;
  localparam int unsigned HLD    = 10;
  localparam int unsigned RDIV   = 3;
  localparam logic [7:0]  BOOT   = 8'd40;

  // {vid, offset, expected target}
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {8'h50, 8'h04, 8'h4C},
    {8'h20, 8'h02, 8'h1E},
    {8'h28, 8'h00, 8'h28},
    {8'h05, 8'h09, 8'h00},
    {8'hFE, 8'h00, 8'hFE},
    {8'h30, 8'h30, 8'h00}
  };

  logic             clk;
  logic             rst_n;
  logic             bias_por_ok, pwr_en_ok, vtt_en_ok;
  logic [CODE_W-1:0] vid, vid_offset;
  logic             vid_valid, in_window;
  logic [CODE_W-1:0] ref_code;
  logic             pwm_oe, vr_ready;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  vr_softstart_seq #(
    .CODE_W(CODE_W), .DELAY_CYC(DLY), .HOLD_CYC(HLD), .RAMP_DIV(RDIV),
    .BOOT_CODE(BOOT), .OFF_VID(8'hFF)
  ) i_vr_softstart_seq (
    .clk(clk), .rst_n(rst_n),
    .bias_por_ok(bias_por_ok), .pwr_en_ok(pwr_en_ok), .vtt_en_ok(vtt_en_ok),
    .vid(vid), .vid_valid(vid_valid), .vid_offset(vid_offset),
    .in_window(in_window),
    .ref_code(ref_code), .pwm_oe(pwm_oe), .vr_ready(vr_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic b, input logic p, input logic v);
    bias_por_ok = b;
    pwr_en_ok   = p;
    vtt_en_ok   = v;
  endtask

  // Waits at negedges until vr_ready; returns cycles waited (or lim)
  task automatic wait_ready(input int lim, output int n);
    n = 0;
    while (!vr_ready && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    set_en(1'b0, 1'b0, 1'b0);
    vid = 8'h50; vid_offset = 8'h00; vid_valid = 1'b0; in_window = 1'b0;
    tick(4);
    // R1: reset state
    chk("R1 reset pwm_oe", pwm_oe, 0);
    chk("R1 reset ref_code", ref_code, 0);
    chk("R1 reset vr_ready", vr_ready, 0);
    rst_n = 1'b1;
    tick(4);

    // R1: two of three qualifiers never release shutdown
    set_en(1'b1, 1'b1, 1'b0); tick(60);
    chk("R1 no vtt pwm_oe", pwm_oe, 0);
    set_en(1'b1, 1'b0, 1'b1); tick(60);
    chk("R1 no pwr pwm_oe", pwm_oe, 0);
    set_en(1'b0, 1'b1, 1'b1); in_window = 1'b1; tick(60);
    chk("R1 no bias pwm_oe", pwm_oe, 0);
    chk("R1 no bias ref_code", ref_code, 0);
    chk("R1 no bias vr_ready", vr_ready, 0);
    set_en(1'b0, 1'b0, 1'b0); tick(2);

    // R2: delay length; R3: step timing; R4: indefinite hold without vid_valid
    set_en(1'b1, 1'b1, 1'b1);
    n = 0;
    while (!pwm_oe && n < 200) begin
      @(negedge clk);
      n++;
      if (!pwm_oe) chk("R2 ref zero during delay", ref_code, 0);
      if (!pwm_oe && n > DLY + 2) break;
    end
    chk("R2 edges to pwm_oe", n, DLY + 1);
    n = 0;
    while (ref_code == 0 && n < 50) begin @(negedge clk); n++; end
    chk("R3 first step delay", n, RDIV);
    n = 0;
    while (ref_code == 1 && n < 50) begin @(negedge clk); n++; end
    chk("R3 step interval", n, RDIV);
    chk("R3 step size", ref_code, 2);
    chk("R7 no ready mid ramp", vr_ready, 0);
    tick(RDIV * BOOT + 200);
    chk("R4 hold level without vid_valid", ref_code, BOOT);
    chk("R4 pwm_oe in hold", pwm_oe, 1);
    chk("R3 no overshoot", ref_code, BOOT);

    // R8: drop during hold
    set_en(1'b1, 1'b0, 1'b1); tick(1);
    chk("R8 drop in hold pwm_oe", pwm_oe, 0);
    chk("R8 drop in hold ref_code", ref_code, 0);
    set_en(1'b0, 1'b0, 1'b0); tick(2);

    // R4: exact hold length with vid_valid already high
    vid = 8'h50; vid_offset = 8'h00; vid_valid = 1'b1;
    set_en(1'b1, 1'b1, 1'b1);
    n = 0;
    while (ref_code != BOOT && n < 500) begin @(negedge clk); n++; end
    n = 0;
    while (ref_code == BOOT && n < 500) begin @(negedge clk); n++; end
    chk("R4 boot hold samples", n, HLD + RDIV + 1);
    chk("R5 leaves boot upward", ref_code, BOOT + 1);
    // R8: drop during second ramp
    set_en(1'b0, 1'b1, 1'b1); tick(1);
    chk("R8 drop in ramp pwm_oe", pwm_oe, 0);
    chk("R8 drop in ramp ref_code", ref_code, 0);
    set_en(1'b0, 1'b0, 1'b0); tick(2);

    // Table walk: R5 targets, R7 ready, R9 late VID changes ignored
    for (int i = 0; i < NVEC; i++) begin
      vid = VEC[i][23:16]; vid_offset = VEC[i][15:8];
      vid_valid = 1'b1; in_window = 1'b1;
      set_en(1'b1, 1'b1, 1'b1);
      wait_ready(2000, n);
      chk("R7 ready reached", vr_ready, 1);
      chk("R5 final ref_code", ref_code, VEC[i][7:0]);
      vid = ~vid; vid_offset = 8'h01; tick(20);
      chk("R9 ref_code after VID change", ref_code, VEC[i][7:0]);
      set_en(1'b0, 1'b0, 1'b0); tick(2);
    end

    // R7: ready follows in_window at the final level
    vid = 8'h30; vid_offset = 8'h00; in_window = 1'b0;
    set_en(1'b1, 1'b1, 1'b1);
    tick(DLY + RDIV * 60 + HLD + 40);
    chk("R7 no ready without window", vr_ready, 0);
    chk("R5 at target without window", ref_code, 8'h30);
    in_window = 1'b1; tick(1);
    chk("R7 ready after window", vr_ready, 1);
    in_window = 1'b0; tick(1);
    chk("R7 ready drops with window", vr_ready, 0);
    in_window = 1'b1; tick(1);
    // R8: drop in regulation
    set_en(1'b1, 1'b1, 1'b0); tick(1);
    chk("R8 drop in run pwm_oe", pwm_oe, 0);
    chk("R8 drop in run ref_code", ref_code, 0);
    chk("R8 drop in run vr_ready", vr_ready, 0);
    set_en(1'b0, 1'b0, 1'b0); tick(2);

    // R6: OFF code latches shutdown
    vid = 8'hFF; vid_offset = 8'h00;
    set_en(1'b1, 1'b1, 1'b1);
    tick(DLY + RDIV * BOOT + HLD + 30);
    chk("R6 off pwm_oe", pwm_oe, 0);
    chk("R6 off ref_code", ref_code, 0);
    vid = 8'h30; tick(300);
    chk("R6 lock held pwm_oe", pwm_oe, 0);
    chk("R6 lock held ref_code", ref_code, 0);
    set_en(1'b1, 1'b1, 1'b0); tick(1);
    set_en(1'b1, 1'b1, 1'b1);
    wait_ready(2000, n);
    chk("R6 restart ready", vr_ready, 1);
    chk("R6 restart ref_code", ref_code, 8'h30);

    finish_run();
  end

endmodule